// File: doc/BRIEF.md
# ATA Task-File Status Sequencer

This block is the device side of the command block registers of a single ATA drive. A host reaches it through a narrow register bus with eight offsets. The block holds the sector count, the three address bytes and the device select byte. It accepts command bytes and drives the status byte through its ready, busy and data-request phases. It also owns the interrupt line towards the host.

Two commands are executed. The identify command opens a PIO data-in phase. The host then pulls a fixed number of 16-bit words through the data port. The block fetches each word from an external buffer by index, sets the write-cache bit in word 85 and byte-swaps the serial-number words. The cache flush command is a non-data command. It keeps the drive busy until an external completion pulse arrives. Any other opcode is rejected with an abort error. Reading the status byte acknowledges the interrupt.

Top module: `taskfile_seq`

## Requirements
- R1: After reset the status byte reads 0x40, the interrupt is low, and offsets 2 to 6 read 0x00.
- R2: Offset map: 0 data, 1 feature on write and error on read, 2 sector count, 3/4/5 address low/middle/high, 6 device, 7 command on write and status on read. Bytes written to offsets 2 to 6 read back unchanged in the low byte of the read data, with the high byte 0.
- R3: Status bits are busy 0x80, ready 0x40, fault 0x20, data request 0x08 and error 0x01. The fault bit is never set.
- R4: Command 0xEC raises the interrupt and makes the status read 0x48 for each of exactly WORDS data-port reads. After the last one the status reads 0x40.
- R5: The k-th data read in an identify phase returns buffer word k, with two changes. Bit 5 of word 85 is forced to 1. Words 10 to 19 have their two bytes swapped.
- R6: Command 0xE7 makes the status read 0xC0 until a flush_done pulse. That pulse makes the status read 0x40 and raises the interrupt. A flush_done pulse outside a flush has no effect.
- R7: A status read lowers the interrupt on the next edge, unless a new interrupt event happens on that same edge.
- R8: Any other opcode makes the status read 0x41, the error register read 0x04 and raises the interrupt. The next accepted command clears the error.
- R9: Command writes while the busy bit is set are ignored.
- R10: While device-register bit 4 is 1 (drive 1 selected), command writes are ignored. Bit 6 (address mode) is only stored.
- R11: Outside a data-request phase, data-port reads return 0x0000 and do not advance the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| flush_done | input | 1 | Completion pulse for an outstanding flush |
| buf_addr | output | $clog2(WORDS) | Index of the identify word being presented |
| buf_word | input | 16 | Identify word at buf_addr |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with its defaults: WORDS of 256, the cache flag in word 85 bit 5 and serial words 10 to 19. With these values the whole identify phase is swept word by word. The bench checks both the status byte and the data word at each of the 256 positions. This covers the exact end of the data phase and both overlay regions. A value sweep over the five byte registers, and the flush, reject, busy-ignore and drive-select sequences, reach every state transition of the sequencer.

// File: rtl/tfseq_pkg.sv
package tfseq_pkg;

    localparam logic [7:0] ST_BUSY  = 8'h80;
    localparam logic [7:0] ST_READY = 8'h40;
    localparam logic [7:0] ST_FAULT = 8'h20;
    localparam logic [7:0] ST_DREQ  = 8'h08;
    localparam logic [7:0] ST_ERROR = 8'h01;

    localparam logic [7:0] OP_IDENTIFY = 8'hEC;
    localparam logic [7:0] OP_FLUSH    = 8'hE7;

    localparam logic [7:0] ERRREG_ABORT = 8'h04;

    localparam int DEV_DRIVE_BIT = 4;

    typedef enum logic [2:0] {
        OFS_DATA  = 3'd0,
        OFS_FEAT  = 3'd1,
        OFS_COUNT = 3'd2,
        OFS_ADR0  = 3'd3,
        OFS_ADR1  = 3'd4,
        OFS_ADR2  = 3'd5,
        OFS_DEV   = 3'd6,
        OFS_CMDST = 3'd7
    } tf_ofs_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_XFER  = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        CK_IDENT = 2'd0,
        CK_FLUSH = 2'd1,
        CK_BAD   = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic [7:0] count;
        logic [7:0] adr_lo;
        logic [7:0] adr_mid;
        logic [7:0] adr_hi;
        logic [7:0] device;
    } tf_regs_t;

    function automatic cmd_kind_e classify(input logic [7:0] op);
        cmd_kind_e k;
        case (op)
            OP_IDENTIFY: k = CK_IDENT;
            OP_FLUSH:    k = CK_FLUSH;
            default:     k = CK_BAD;
        endcase
        return k;
    endfunction

    function automatic logic [7:0] status_byte(input phase_e ph, input logic err);
        logic [7:0] s;
        case (ph)
            PH_XFER:  s = ST_READY | ST_DREQ;
            PH_FLUSH: s = ST_BUSY | ST_READY;
            default:  s = ST_READY | (err ? ST_ERROR : 8'h00);
        endcase
        return s;
    endfunction

    function automatic logic [15:0] swap16(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/tfseq_regs.sv
module tfseq_regs
    import tfseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output tf_regs_t   regs,
    output logic       cmd_stb,
    output logic [7:0] cmd_op,
    output logic       drive_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_COUNT: regs.count   <= wdata;
                OFS_ADR0:  regs.adr_lo  <= wdata;
                OFS_ADR1:  regs.adr_mid <= wdata;
                OFS_ADR2:  regs.adr_hi  <= wdata;
                OFS_DEV:   regs.device  <= wdata;
                default: ;
            endcase
        end
    end

    assign cmd_stb   = wr_en && (addr == OFS_CMDST);
    assign cmd_op    = wdata;
    assign drive_sel = regs.device[DEV_DRIVE_BIT];

    // R2: a byte register only changes on a write to its own offset
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFS_COUNT) |=> $stable(regs.count));

    assert_device_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFS_DEV) |=> $stable(regs.device));

endmodule

// File: rtl/tfseq_ctrl.sv
module tfseq_ctrl
    import tfseq_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_stb,
    input  logic [7:0]    cmd_op,
    input  logic          drive_sel,
    input  logic          data_rd,
    input  logic          status_rd,
    input  logic          flush_done,
    output phase_e        phase,
    output logic          err_flag,
    output logic          irq,
    output logic [AW-1:0] word_idx
);

    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    logic      accept;
    logic      raise;
    cmd_kind_e kind;

    assign kind   = classify(cmd_op);
    assign accept = cmd_stb && (phase != PH_FLUSH) && !drive_sel;

    always_comb begin
        raise = 1'b0;
        if (accept) begin
            raise = (kind != CK_FLUSH);
        end else if (phase == PH_FLUSH && flush_done) begin
            raise = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            err_flag <= 1'b0;
            word_idx <= '0;
        end else if (accept) begin
            word_idx <= '0;
            case (kind)
                CK_IDENT: begin
                    phase    <= PH_XFER;
                    err_flag <= 1'b0;
                end
                CK_FLUSH: begin
                    phase    <= PH_FLUSH;
                    err_flag <= 1'b0;
                end
                default: begin
                    phase    <= PH_IDLE;
                    err_flag <= 1'b1;
                end
            endcase
        end else if (phase == PH_XFER && data_rd) begin
            if (word_idx == LAST_IDX) begin
                phase    <= PH_IDLE;
                word_idx <= '0;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end else if (phase == PH_FLUSH && flush_done) begin
            phase <= PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (raise) begin
            irq <= 1'b1;
        end else if (status_rd) begin
            irq <= 1'b0;
        end
    end

    // R6: busy holds until the completion pulse
    assert_flush_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FLUSH && !flush_done) |=> (phase == PH_FLUSH));

    // R9: command strobes during busy leave the error state alone
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FLUSH && cmd_stb) |=> $stable(err_flag));

    // R7: a status read with no new event drops the interrupt
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !raise) |=> !irq);

    // R4: the data phase only moves on a data read or a new command
    assert_xfer_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_XFER && !data_rd && !cmd_stb) |=> (phase == PH_XFER && $stable(word_idx)));

    // R11: the word index stays at zero outside the data phase
    assert_idx_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_XFER) |-> (word_idx == '0));

    // R10: drive 1 selected, idle: a command changes nothing
    assert_drive1_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && drive_sel && phase == PH_IDLE) |=> (phase == PH_IDLE && $stable(err_flag)));

endmodule

// File: rtl/tfseq_dport.sv
module tfseq_dport
    import tfseq_pkg::*;
#(
    parameter int WORDS        = 256,
    parameter int CACHE_WORD   = 85,
    parameter int CACHE_BIT    = 5,
    parameter int SERIAL_FIRST = 10,
    parameter int SERIAL_LAST  = 19,
    parameter bit SWAP_SERIAL  = 1'b1,
    localparam int AW = $clog2(WORDS)
) (
    input  logic [AW-1:0] word_idx,
    input  logic          drq,
    input  logic [15:0]   buf_word,
    output logic [15:0]   data_word
);

    logic [15:0] shaped;
    logic        in_serial;

    assign in_serial = (32'(word_idx) >= SERIAL_FIRST) && (32'(word_idx) <= SERIAL_LAST);

    generate
        if (SWAP_SERIAL) begin : g_swap
            always_comb begin
                shaped = in_serial ? swap16(buf_word) : buf_word;
                if (32'(word_idx) == CACHE_WORD) shaped[CACHE_BIT] = 1'b1;
            end
        end else begin : g_plain
            always_comb begin
                shaped = buf_word;
                if (32'(word_idx) == CACHE_WORD) shaped[CACHE_BIT] = 1'b1;
            end
        end
    endgenerate

    assign data_word = drq ? shaped : 16'h0000;

    // R11: the data port is silent outside a data-request phase
    always_comb begin
        if (!drq) assert_quiet_port_R11: assert (data_word == 16'h0000);
    end

endmodule

// File: rtl/taskfile_seq.sv
module taskfile_seq
    import tfseq_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          flush_done,
    output logic [AW-1:0] buf_addr,
    input  logic [15:0]   buf_word,
    output logic          irq
);

    tf_regs_t      regs;
    logic          cmd_stb;
    logic [7:0]    cmd_op;
    logic          drive_sel;
    phase_e        phase;
    logic          err_flag;
    logic [AW-1:0] word_idx;
    logic [15:0]   data_word;
    logic          data_rd;
    logic          status_rd;
    logic [7:0]    status;

    assign data_rd   = bus_rd && (bus_addr == OFS_DATA);
    assign status_rd = bus_rd && (bus_addr == OFS_CMDST);
    assign status    = status_byte(phase, err_flag);

    tfseq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .regs      (regs),
        .cmd_stb   (cmd_stb),
        .cmd_op    (cmd_op),
        .drive_sel (drive_sel)
    );

    tfseq_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_stb    (cmd_stb),
        .cmd_op     (cmd_op),
        .drive_sel  (drive_sel),
        .data_rd    (data_rd),
        .status_rd  (status_rd),
        .flush_done (flush_done),
        .phase      (phase),
        .err_flag   (err_flag),
        .irq        (irq),
        .word_idx   (word_idx)
    );

    tfseq_dport #(.WORDS(WORDS)) u_dport (
        .word_idx  (word_idx),
        .drq       (phase == PH_XFER),
        .buf_word  (buf_word),
        .data_word (data_word)
    );

    assign buf_addr = word_idx;

    always_comb begin
        case (bus_addr)
            OFS_DATA:  bus_rdata = data_word;
            OFS_FEAT:  bus_rdata = {8'h00, err_flag ? ERRREG_ABORT : 8'h00};
            OFS_COUNT: bus_rdata = {8'h00, regs.count};
            OFS_ADR0:  bus_rdata = {8'h00, regs.adr_lo};
            OFS_ADR1:  bus_rdata = {8'h00, regs.adr_mid};
            OFS_ADR2:  bus_rdata = {8'h00, regs.adr_hi};
            OFS_DEV:   bus_rdata = {8'h00, regs.device};
            default:   bus_rdata = {8'h00, status};
        endcase
    end

    // R3: the fault bit never shows and busy never pairs with data request
    always_comb begin
        assert_status_legal_R3: assert ((status & ST_FAULT) == 8'h00 &&
            !((status & ST_BUSY) != 8'h00 && (status & ST_DREQ) != 8'h00));
    end

endmodule

// File: tb/taskfile_seq_bench.sv
module taskfile_seq_bench;

    localparam int WORDS = 256;
    localparam int AW = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          flush_done = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [15:0]   buf_word;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign buf_word = {buf_addr ^ 8'hC3, buf_addr};

    taskfile_seq #(.WORDS(WORDS)) u_taskfile_seq (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flush_done(flush_done), .buf_addr(buf_addr), .buf_word(buf_word), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        flush_done = 1'b1;
        @(posedge clk); #1;
        flush_done = 1'b0;
    endtask

    function automatic logic [15:0] exp_word(input int k);
        logic [15:0] w;
        w = {8'(k) ^ 8'hC3, 8'(k)};
        if (k >= 10 && k <= 19) w = {w[7:0], w[15:8]};
        if (k == 85) w[5] = 1'b1;
        return w;
    endfunction

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 irq", {15'h0, irq}, 16'h0000);
        rd(3'd7, v); check("R1 status", v, 16'h0040);
        for (int a = 2; a <= 6; a++) begin
            rd(3'(a), v); check("R1 regs", v, 16'h0000);
        end

        // R2 register sweep
        for (int a = 2; a <= 6; a++) begin
            for (int x = 0; x < 256; x += 17) begin
                logic [7:0] val;
                val = (a == 6) ? (8'(x) & 8'hEF) : 8'(x);
                wr(3'(a), val);
                rd(3'(a), v); check("R2 readback", v, {8'h00, val});
            end
        end
        wr(3'd6, 8'h40);
        wr(3'd1, 8'h55);
        rd(3'd1, v); check("R2 feature not echoed", v, 16'h0000);

        // R11 idle data port
        rd(3'd0, v); check("R11 idle data", v, 16'h0000);

        // R4/R5 identify sweep
        wr(3'd7, 8'hEC);
        check("R4 irq raised", {15'h0, irq}, 16'h0001);
        for (int k = 0; k < WORDS; k++) begin
            rd(3'd7, v); check("R4 status during data", v, 16'h0048);
            if (k == 0) check("R7 irq cleared", {15'h0, irq}, 16'h0000);
            rd(3'd0, v); check("R5 data word", v, exp_word(k));
        end
        rd(3'd7, v); check("R4 status after last", v, 16'h0040);
        rd(3'd0, v); check("R11 data after phase", v, 16'h0000);
        check("R4 no irq at end", {15'h0, irq}, 16'h0000);

        // R11 reads outside the phase do not advance: restart begins at word 0
        rd(3'd0, v); rd(3'd0, v);
        wr(3'd7, 8'hEC);
        rd(3'd0, v); check("R11 restart word0", v, exp_word(0));
        rd(3'd0, v); check("R11 restart word1", v, exp_word(1));

        // R6/R9 flush
        wr(3'd7, 8'hE7);
        for (int c = 0; c < 4; c++) begin
            rd(3'd7, v); check("R6 busy", v, 16'h00C0);
        end
        wr(3'd7, 8'hEC);
        rd(3'd7, v); check("R9 cmd ignored while busy", v, 16'h00C0);
        rd(3'd0, v); check("R11 data while busy", v, 16'h0000);
        rd(3'd7, v);
        check("R6 no irq while busy", {15'h0, irq}, 16'h0000);
        pulse_done();
        check("R6 irq on done", {15'h0, irq}, 16'h0001);
        rd(3'd7, v); check("R6 status after done", v, 16'h0040);
        check("R7 irq cleared", {15'h0, irq}, 16'h0000);
        pulse_done();
        check("R6 stray done", {15'h0, irq}, 16'h0000);
        rd(3'd7, v); check("R6 stray done status", v, 16'h0040);

        // R8 unsupported opcode
        wr(3'd7, 8'h91);
        check("R8 irq", {15'h0, irq}, 16'h0001);
        rd(3'd1, v); check("R8 error reg", v, 16'h0004);
        check("R7 non-status read keeps irq", {15'h0, irq}, 16'h0001);
        rd(3'd7, v); check("R8 status", v, 16'h0041);
        wr(3'd7, 8'hE7);
        rd(3'd7, v); check("R8 error cleared", v, 16'h00C0);
        rd(3'd1, v); check("R8 error reg cleared", v, 16'h0000);
        pulse_done();
        rd(3'd7, v); check("R3 ready only", v, 16'h0040);

        // R10 drive 1 selected
        wr(3'd6, 8'h50);
        wr(3'd7, 8'hEC);
        check("R10 no irq", {15'h0, irq}, 16'h0000);
        rd(3'd7, v); check("R10 status unchanged", v, 16'h0040);
        wr(3'd7, 8'h91);
        rd(3'd1, v); check("R10 no error", v, 16'h0000);
        wr(3'd6, 8'h40);
        wr(3'd7, 8'hEC);
        rd(3'd7, v); check("R10 drive 0 accepts", v, 16'h0048);

        // R7 raise wins over same-edge status read: new command + status read
        @(negedge clk);
        bus_addr = 3'd7; bus_wdata = 8'h91; bus_wr = 1'b1; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R7 raise wins", {15'h0, irq}, 16'h0001);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R1 irq after reset", {15'h0, irq}, 16'h0000);
        rd(3'd7, v); check("R1 status after reset", v, 16'h0040);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule